// File: doc/BRIEF.md
# Reloading Modulus Up-Counter

This block is a 16-bit up-counter that works with a 16-bit reload register, called the modulus latch. The counter advances by one on each clock-enable pulse from a shared prescaler. Those pulses count only after software has set the prescaler's run bit. When the counter passes its maximum value, it takes its next value from the latch and sets a sticky overflow flag. It then raises an interrupt request if interrupts are enabled. An edge on an external load pin can also reload the counter from the latch. A two-bit field selects which edge is used.

Software reaches the block through a simple register port with a write strobe, a 2-bit address and combinational read data. Address 0 is the latch, address 1 is the counter and address 2 is the control word. A write to the latch changes only the latch, and the counter picks up that value at its next hardware reload. A write to the counter stores the same value in both the counter and the latch.

Top module: `modctr_top`

## Requirements
- R1: After reset the latch (addr 0), the counter (addr 1) and the control word (addr 2) all read 0x0000, and `irq` is low.
- R2: While `run` is high, each cycle with `tick` high adds one to the counter.
- R3: While `run` is low, `tick` pulses leave the counter unchanged.
- R4: A write to addr 0 changes the latch only. The counter keeps its value.
- R5: A write to addr 1 puts the written value into both the counter and the latch on the same clock edge.
- R6: A counted tick at 0xFFFF loads the counter from the latch and sets the overflow flag, which is control bit 3.
- R7: The overflow flag stays set until a control write with bit 3 at 1. A control write with bit 3 at 0 leaves the flag unchanged.
- R8: `irq` is high exactly while the overflow flag and the interrupt enable (control bit 2) are both set.
- R9: Writing 0x0000 to the counter while it holds 0xFFFF does not set the flag and does not raise `irq`.
- R10: With the latch at 0xFFFF, every counted tick sets the overflow flag, and the counter stays at 0xFFFF.
- R11: Control bits [1:0] choose the pin edge that reloads the counter: 00 none, 01 rising, 10 falling, 11 both. The reload shows up at the third rising clock edge after the pin changes.
- R12: Changing the edge select while the pin is steady never causes a reload.
- R13: When a counter write and a hardware reload or overflow fall in the same cycle, the written value wins and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 latch, 1 counter, 2 control) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| run | input | 1 | Prescaler run bit |
| tick | input | 1 | Counter clock-enable pulse from the prescaler |
| load_pin | input | 1 | Asynchronous external reload input |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, counted ticks and overflow take effect at the next rising edge. Their results can therefore be read back on the following falling edge, because `rdata` and `irq` are combinational. A pin edge needs three rising edges: two synchronizer stages and the edge-compare register. The bench therefore waits four falling edges after moving the pin before it queues the expected counter value. Every expected item is pushed into the queue only after the stimulus task has returned at a falling edge. The monitor compares it one time unit later, away from any clock edge.

// File: rtl/modctr_pkg.sv
// Package: shared constants and types for the modulus counter.
// Assumes a 2-bit register address space.
package modctr_pkg;
    localparam logic [1:0] ADDR_LATCH = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    // Control-word bit positions
    localparam int CTRL_IE_BIT  = 2;
    localparam int CTRL_OVF_BIT = 3;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/modctr_edge.sv
// Edge detector for the external reload pin.
// It synchronizes the pin through SYNC_STAGES flops and keeps the last
// synchronized sample whatever the edge select is. A change of the select
// therefore never compares against a stale sample.
// Assumes pin_i is asynchronous to clk.
module modctr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] sel_i,
    output logic       load_o
);
    import modctr_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   rise;
    logic                   fall;
    edge_sel_e              sel;

    // Synchronizer chain: stage 0 samples the pin, the others shift it along
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)      sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= pin_i;
                else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    // Previous-sample register, updated every cycle whatever the select is
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Edge qualification by the selected mode
    always_comb begin
        sel  = edge_sel_e'(sel_i);
        rise = cur & ~prev_q;
        fall = ~cur & prev_q;
        unique case (sel)
            EDGE_NONE: load_o = 1'b0;
            EDGE_RISE: load_o = rise;
            EDGE_FALL: load_o = fall;
            EDGE_BOTH: load_o = rise | fall;
            default:   load_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/modctr_core.sv
// Counter core: modulus latch, loadable up-counter and sticky overflow flag.
// A software counter write has priority over a hardware reload and hides any
// overflow in the same cycle. Setting the flag has priority over clearing it.
module modctr_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en_i,
    input  logic         hw_load_i,
    input  logic         cnt_wr_i,
    input  logic         lat_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] lat_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] lat_q;
    logic         ovf_q;
    logic         wrap;

    // Overflow event: a counted tick at the top value, unless software writes
    assign wrap = count_en_i & (cnt_q == CNT_MAX) & ~cnt_wr_i;

    // Counter update with priority: software write, reload, increment
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cnt_wr_i)           cnt_q <= wdata_i;
        else if (wrap || hw_load_i)  cnt_q <= lat_q;
        else if (count_en_i)         cnt_q <= cnt_q + 1'b1;
    end

    // Latch update from either software write path
    always_ff @(posedge clk) begin
        if (!rst_n)                    lat_q <= '0;
        else if (cnt_wr_i || lat_wr_i) lat_q <= wdata_i;
    end

    // Sticky overflow flag, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (wrap)      ovf_q <= 1'b1;
        else if (ovf_clr_i) ovf_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign lat_o = lat_q;
    assign ovf_o = ovf_q;
endmodule

// File: rtl/modctr_top.sv
// Top level: decodes register accesses, holds the control word, gates
// prescaler ticks with the run bit and drives the interrupt request.
// Assumes run and tick are synchronous to clk.
module modctr_top #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         run,
    input  logic         tick,
    input  logic         load_pin,
    output logic         irq
);
    import modctr_pkg::*;

    logic [1:0]   edge_sel_q;
    logic         ie_q;
    logic         cnt_wr, lat_wr, ctrl_wr;
    logic         pin_load;
    logic [W-1:0] cnt, lat;
    logic         ovf;
    logic         count_en;

    // Write decode
    assign cnt_wr   = wr_en && (addr == ADDR_COUNT);
    assign lat_wr   = wr_en && (addr == ADDR_LATCH);
    assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
    assign count_en = run & tick;

    // Control word: edge select and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel_q <= 2'b00;
            ie_q       <= 1'b0;
        end else if (ctrl_wr) begin
            edge_sel_q <= wdata[1:0];
            ie_q       <= wdata[CTRL_IE_BIT];
        end
    end

    modctr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (load_pin),
        .sel_i  (edge_sel_q),
        .load_o (pin_load)
    );

    modctr_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en),
        .hw_load_i  (pin_load),
        .cnt_wr_i   (cnt_wr),
        .lat_wr_i   (lat_wr),
        .wdata_i    (wdata),
        .ovf_clr_i  (ctrl_wr && wdata[CTRL_OVF_BIT]),
        .cnt_o      (cnt),
        .lat_o      (lat),
        .ovf_o      (ovf)
    );

    // Read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_LATCH: rdata = lat;
            ADDR_COUNT: rdata = cnt;
            ADDR_CTRL: begin
                rdata[1:0]          = edge_sel_q;
                rdata[CTRL_IE_BIT]  = ie_q;
                rdata[CTRL_OVF_BIT] = ovf;
            end
            default: rdata = '0;
        endcase
    end

    // Interrupt request
    assign irq = ovf & ie_q;
endmodule

// File: rtl/modctr_chk.sv
// Checker for modctr_top: properties over register writes, counter state and
// the interrupt. Attached to every modctr_top instance by the bind below.
module modctr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic         run,
    input logic         load_pin,
    input logic [W-1:0] cnt,
    input logic [W-1:0] lat,
    input logic         ovf,
    input logic         ie,
    input logic         irq
);
    assert_lat_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (lat == $past(wdata)));

    assert_cnt_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (cnt == $past(wdata) && lat == $past(wdata)));

    assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == 2'd1) && $stable(load_pin)
            && $past(load_pin) == load_pin) |=> $stable(cnt) || $past(lat) == cnt);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && addr == 2'd2 && wdata[3])) |=> ovf);

    assert_no_irq_without_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |-> !irq);

    assert_no_irq_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    assert_zero_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && !ovf && !(wr_en && addr == 2'd2)) |=> !ovf);
endmodule

bind modctr_top modctr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .run      (run),
    .load_pin (load_pin),
    .cnt      (cnt),
    .lat      (lat),
    .ovf      (ovf),
    .ie       (ie_q),
    .irq      (irq)
);

// File: tb/modctr_top_tb.sv
module modctr_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        run = 1'b0;
    logic        tick = 1'b0;
    logic        load_pin = 1'b0;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    modctr_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .run(run), .tick(tick), .load_pin(load_pin), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [1:0]  a;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t queue_q[$];
    event  chk_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // Monitor: pops each expected item and compares it to the outputs
    initial forever begin
        @(chk_ev);
        #1;
        while (queue_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = queue_q.pop_front();
            act = it.is_irq ? {15'd0, irq} : rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.a, act, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string r);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_irq = 0; it.a = a; it.exp = e; it.req = r;
        queue_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic expect_irq(input logic e, input string r);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.a = addr; it.exp = {15'd0, e}; it.req = r;
        queue_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic move_pin(input logic v);
        @(negedge clk);
        load_pin = v;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg(2'd0, 16'h0000, "R1");
        expect_reg(2'd1, 16'h0000, "R1");
        expect_reg(2'd2, 16'h0000, "R1");
        expect_irq(1'b0, "R1");
        // R3 run gate
        pulse_tick(3);
        expect_reg(2'd1, 16'h0000, "R3");
        // R2 counting
        run = 1'b1;
        pulse_tick(3);
        expect_reg(2'd1, 16'h0003, "R2");
        // R4 latch-only write
        write_reg(2'd0, 16'h1234);
        expect_reg(2'd0, 16'h1234, "R4");
        expect_reg(2'd1, 16'h0003, "R4");
        // R5 counter write loads both
        write_reg(2'd1, 16'hFFFE);
        expect_reg(2'd1, 16'hFFFE, "R5");
        expect_reg(2'd0, 16'hFFFE, "R5");
        // R6 overflow reload
        write_reg(2'd0, 16'h0100);
        pulse_tick(1);
        expect_reg(2'd1, 16'hFFFF, "R6");
        expect_reg(2'd2, 16'h0000, "R6");
        pulse_tick(1);
        expect_reg(2'd1, 16'h0100, "R6");
        expect_reg(2'd2, 16'h0008, "R6");
        expect_irq(1'b0, "R8");
        // R7 / R8 sticky flag and interrupt
        write_reg(2'd2, 16'h0004);
        expect_reg(2'd2, 16'h000C, "R7");
        expect_irq(1'b1, "R8");
        write_reg(2'd2, 16'h000C);
        expect_reg(2'd2, 16'h0004, "R7");
        expect_irq(1'b0, "R8");
        // R9 zero write at top value
        write_reg(2'd1, 16'hFFFF);
        write_reg(2'd1, 16'h0000);
        expect_reg(2'd1, 16'h0000, "R9");
        expect_reg(2'd2, 16'h0004, "R9");
        expect_irq(1'b0, "R9");
        // R10 latch at top value
        write_reg(2'd1, 16'hFFFF);
        pulse_tick(1);
        expect_reg(2'd2, 16'h000C, "R10");
        expect_reg(2'd1, 16'hFFFF, "R10");
        write_reg(2'd2, 16'h000C);
        expect_reg(2'd2, 16'h0004, "R10");
        pulse_tick(1);
        expect_reg(2'd2, 16'h000C, "R10");
        write_reg(2'd2, 16'h000C);
        // R11 / R12 pin edges
        write_reg(2'd1, 16'h0005);
        write_reg(2'd0, 16'h00AA);
        move_pin(1'b1);
        expect_reg(2'd1, 16'h0005, "R11");
        write_reg(2'd2, 16'h0005);
        repeat (4) @(negedge clk);
        expect_reg(2'd1, 16'h0005, "R12");
        move_pin(1'b0);
        expect_reg(2'd1, 16'h0005, "R11");
        move_pin(1'b1);
        expect_reg(2'd1, 16'h00AA, "R11");
        write_reg(2'd1, 16'h0005);
        write_reg(2'd0, 16'h00AA);
        write_reg(2'd2, 16'h0006);
        move_pin(1'b0);
        expect_reg(2'd1, 16'h00AA, "R11");
        write_reg(2'd1, 16'h0005);
        write_reg(2'd0, 16'h00AA);
        move_pin(1'b1);
        expect_reg(2'd1, 16'h0005, "R11");
        write_reg(2'd2, 16'h0007);
        move_pin(1'b0);
        expect_reg(2'd1, 16'h00AA, "R11");
        write_reg(2'd1, 16'h0005);
        write_reg(2'd0, 16'h00AA);
        move_pin(1'b1);
        expect_reg(2'd1, 16'h00AA, "R11");
        write_reg(2'd2, 16'h0004);
        expect_reg(2'd1, 16'h00AA, "R12");
        // R13 software write beats overflow
        write_reg(2'd1, 16'hFFFF);
        @(negedge clk);
        addr = 2'd1; wdata = 16'h0007; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        expect_reg(2'd1, 16'h0007, "R13");
        expect_reg(2'd0, 16'h0007, "R13");
        expect_reg(2'd2, 16'h0004, "R13");
        expect_irq(1'b0, "R13");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule